// File: doc/BRIEF.md
# Three-wire serial word memory slave

This block is the device side of a three-wire serial memory link: a select line, a serial clock, a data-in line and a data-out line with its own output-enable. It samples the serial pins in the system clock domain and detects serial clock rising edges and select transitions there. The first '1' after select goes high is a start bit. A two-bit opcode follows, then an eight-bit address, both MSB first. The stored data is a register array of 16-bit words.

Four commands are handled. Read (opcode `10`) sends a dummy zero and then streams words, moving to the next address while clocking continues. Write (opcode `01`) takes a 16-bit word after the address and commits it when select falls. The control opcode `00` turns writes on or off through a latch that is cleared by reset. While the self-timed write runs, raising select shows busy or ready on data out.

Top module: `mw_eeprom_slave`

## Requirements
- R1: While select is high and no command is running, data-in bits sampled as '0' on serial clock rising edges are skipped. The first '1' is the start bit of a command, and any number of leading zeros does not change the result.
- R2: After start bit, opcode `10` and an 8-bit address (MSB first), the serial clock edge that samples A0 drives data out to '0' with the enable on. Each of the next 16 serial clock rising edges drives one data bit, D15 first.
- R3: If select stays high during a read, the 17th edge after A0 starts the word at the next address, D15 first, with no dummy bit. The address wraps from 255 to 0.
- R4: Opcode `01`, then an 8-bit address and 16 data bits (MSB first), stores the word when select falls after the edge that sampled D0, provided writes are enabled.
- R5: After reset writes are disabled. A write command while disabled changes no word and starts no busy period.
- R6: Opcode `00` followed by select bits `11` enables writes, and followed by `00` disables them. Serial clock edges after these two bits are ignored whatever data in holds.
- R7: A read returns stored data whether writes are enabled or disabled.
- R8: For WR_CYCLES clock cycles after a committed write, raising select turns the enable on and drives data out '0'. Once that time has passed, data out reads '1'.
- R9: No command is accepted while the write is in progress. Start bits then have no effect.
- R10: The data-out enable is off whenever select is low, and also while a command is being received.
- R11: Select falling at any point aborts the command in progress. A write aborted before D0 changes no word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select, active high |
| sclk | input | 1 | Serial clock, synchronous to clk |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_en | output | 1 | Output enable for sdo (low means high impedance) |

## Verification
A serial clock or select edge that is driven is seen at the next rising edge of clk, and data out is registered at that same edge. Every serial bit result is therefore due one system clock after the serial clock rises. The bench holds the serial clock high for two clock periods and samples on a falling clock edge in between. A write's busy window runs exactly WR_CYCLES clocks after the edge at which select falls. The bench reads status a few clocks into that window and again well after it, so no check falls on the boundary cycle.

// File: rtl/mw_pkg.sv
package mw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OP,
        ST_ADDR,
        ST_WDATA,
        ST_WAIT,
        ST_RD,
        ST_TAIL
    } mw_state_e;

    typedef enum logic [1:0] {
        OP_CTL   = 2'b00,
        OP_WR    = 2'b01,
        OP_RD    = 2'b10,
        OP_OTHER = 2'b11
    } mw_op_e;

    localparam logic [1:0] SEL_EN  = 2'b11;
    localparam logic [1:0] SEL_DIS = 2'b00;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/mw_pin_sync.sv
module mw_pin_sync (
    input  logic clk,
    input  logic rst,
    input  logic cs,
    input  logic sclk,
    output logic sk_rise,
    output logic cs_rise,
    output logic cs_fall
);
    logic sk_q;
    logic cs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sk_q <= 1'b0;
            cs_q <= 1'b0;
        end else begin
            sk_q <= sclk;
            cs_q <= cs;
        end
    end

    assign sk_rise = sclk & ~sk_q;
    assign cs_rise = cs & ~cs_q;
    assign cs_fall = ~cs & cs_q;
endmodule

// File: rtl/mw_word_store.sv
module mw_word_store #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] words [DEPTH];

    always_ff @(posedge clk) begin
        if (we) words[waddr] <= wdata;
    end

    assign rdata = words[raddr];
endmodule

// File: rtl/mw_busy_timer.sv
module mw_busy_timer #(
    parameter int WR_CYCLES = 400
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);
    localparam int TW = $clog2(WR_CYCLES + 1);

    logic [TW-1:0] left;

    always_ff @(posedge clk) begin
        if (rst)                left <= '0;
        else if (start)         left <= TW'(WR_CYCLES);
        else if (left != '0)    left <= left - 1'b1;
    end

    assign busy = (left != '0);
endmodule

// File: rtl/mw_cmd_fsm.sv
module mw_cmd_fsm
    import mw_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs,
    input  logic              sdi,
    input  logic              sk_rise,
    input  logic              cs_rise,
    input  logic              cs_fall,
    input  logic              busy,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_go,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              sdo,
    output logic              sdo_en,
    output logic              wen_o,
    output mw_state_e         st_o
);
    localparam int CNT_W = $clog2(max_of(ADDR_W, DATA_W));
    localparam int BI_W  = $clog2(DATA_W);

    mw_state_e         st;
    mw_op_e            op_q;
    logic [CNT_W-1:0]  cnt;
    logic [BI_W-1:0]   bi;
    logic [BI_W-1:0]   idx;
    logic [ADDR_W-1:0] addr_sh;
    logic [DATA_W-1:0] data_sh;
    logic [ADDR_W-1:0] rd_ptr;
    logic              wen;
    logic              stat;
    logic              dout;

    assign idx = BI_W'(DATA_W - 1) - bi;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            op_q    <= OP_CTL;
            cnt     <= '0;
            bi      <= '0;
            addr_sh <= '0;
            data_sh <= '0;
            rd_ptr  <= '0;
            wen     <= 1'b0;
            stat    <= 1'b0;
            dout    <= 1'b0;
        end else if (!cs) begin
            st   <= ST_IDLE;
            stat <= 1'b0;
        end else begin
            if (cs_rise && busy) stat <= 1'b1;
            if (sk_rise) begin
                unique case (st)
                    ST_IDLE: begin
                        if (sdi && !busy) begin
                            st   <= ST_OP;
                            cnt  <= '0;
                            stat <= 1'b0;
                        end
                    end
                    ST_OP: begin
                        op_q <= mw_op_e'({op_q[0], sdi});
                        if (cnt == CNT_W'(1)) begin
                            st  <= ST_ADDR;
                            cnt <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_ADDR: begin
                        addr_sh <= {addr_sh[ADDR_W-2:0], sdi};
                        cnt     <= cnt + 1'b1;
                        if (op_q == OP_CTL) begin
                            if (cnt == CNT_W'(1)) begin
                                if ({addr_sh[0], sdi} == SEL_EN)       wen <= 1'b1;
                                else if ({addr_sh[0], sdi} == SEL_DIS) wen <= 1'b0;
                                st <= ST_TAIL;
                            end
                        end else if (cnt == CNT_W'(ADDR_W - 1)) begin
                            case (op_q)
                                OP_RD: begin
                                    st     <= ST_RD;
                                    rd_ptr <= {addr_sh[ADDR_W-2:0], sdi};
                                    bi     <= '0;
                                    dout   <= 1'b0;
                                end
                                OP_WR: begin
                                    st  <= ST_WDATA;
                                    cnt <= '0;
                                end
                                default: st <= ST_TAIL;
                            endcase
                        end
                    end
                    ST_WDATA: begin
                        data_sh <= {data_sh[DATA_W-2:0], sdi};
                        if (cnt == CNT_W'(DATA_W - 1)) st <= ST_WAIT;
                        else                           cnt <= cnt + 1'b1;
                    end
                    ST_RD: begin
                        dout <= rd_data[idx];
                        if (bi == BI_W'(DATA_W - 1)) begin
                            bi     <= '0;
                            rd_ptr <= rd_ptr + 1'b1;
                        end else begin
                            bi <= bi + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign rd_addr = rd_ptr;
    assign wr_addr = addr_sh;
    assign wr_data = data_sh;
    assign wr_go   = cs_fall && (st == ST_WAIT) && wen;
    assign sdo_en  = cs && ((st == ST_RD) || stat);
    assign sdo     = stat ? ~busy : dout;
    assign wen_o   = wen;
    assign st_o    = st;
endmodule

// File: rtl/mw_eeprom_slave.sv
module mw_eeprom_slave
    import mw_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 16,
    parameter int WR_CYCLES = 400
) (
    input  logic clk,
    input  logic rst,
    input  logic cs,
    input  logic sclk,
    input  logic sdi,
    output logic sdo,
    output logic sdo_en
);
    logic              sk_rise;
    logic              cs_rise;
    logic              cs_fall;
    logic              busy;
    logic              wr_go;
    logic              wen;
    mw_state_e         st;
    logic [ADDR_W-1:0] rd_addr;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic [DATA_W-1:0] rd_data;

    mw_pin_sync u_sync (
        .clk(clk), .rst(rst), .cs(cs), .sclk(sclk),
        .sk_rise(sk_rise), .cs_rise(cs_rise), .cs_fall(cs_fall)
    );

    mw_cmd_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst(rst), .cs(cs), .sdi(sdi),
        .sk_rise(sk_rise), .cs_rise(cs_rise), .cs_fall(cs_fall),
        .busy(busy), .rd_data(rd_data), .rd_addr(rd_addr),
        .wr_go(wr_go), .wr_addr(wr_addr), .wr_data(wr_data),
        .sdo(sdo), .sdo_en(sdo_en), .wen_o(wen), .st_o(st)
    );

    mw_word_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk(clk), .we(wr_go), .waddr(wr_addr), .wdata(wr_data),
        .raddr(rd_addr), .rdata(rd_data)
    );

    mw_busy_timer #(.WR_CYCLES(WR_CYCLES)) u_timer (
        .clk(clk), .rst(rst), .start(wr_go), .busy(busy)
    );
endmodule

// File: rtl/mw_eeprom_chk.sv
module mw_eeprom_chk
    import mw_pkg::*;
#(
    parameter int WR_CYCLES = 400
) (
    input logic      clk,
    input logic      rst,
    input logic      cs,
    input logic      sdo,
    input logic      sdo_en,
    input logic      busy,
    input logic      wr_go,
    input logic      wen,
    input mw_state_e st
);
    localparam int RW = $clog2(WR_CYCLES + 2);

    logic [RW-1:0] run;

    always_ff @(posedge clk) begin
        if (rst)       run <= '0;
        else if (busy) run <= run + 1'b1;
        else           run <= '0;
    end

    AST_OE_OFF_CS_LOW: assert property (@(posedge clk) disable iff (rst)
        !cs |-> !sdo_en); // R10

    AST_DUMMY_ZERO: assert property (@(posedge clk) disable iff (rst)
        $rose(st == ST_RD) |-> (sdo_en && !sdo)); // R2

    AST_BUSY_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(wr_go)); // R4

    AST_WRITE_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(wen)); // R5

    AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        busy |-> (run < RW'(WR_CYCLES))); // R8

    AST_STATUS_LOW_BUSY: assert property (@(posedge clk) disable iff (rst)
        (sdo_en && st != ST_RD && busy) |-> !sdo); // R8

    AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (rst)
        (busy && st == ST_IDLE) |=> (st == ST_IDLE)); // R9
endmodule

bind mw_eeprom_slave mw_eeprom_chk #(.WR_CYCLES(WR_CYCLES)) chk_i (
    .clk(clk), .rst(rst), .cs(cs), .sdo(sdo), .sdo_en(sdo_en),
    .busy(busy), .wr_go(wr_go), .wen(wen), .st(st)
);

// File: tb/mw_eeprom_slave_tb.sv
module mw_eeprom_slave_tb_top;
    localparam int WR = 400;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs = 1'b0;
    logic sclk = 1'b0;
    logic sdi = 1'b0;
    logic sdo;
    logic sdo_en;

    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    logic last_d, last_oe;
    logic [15:0] rd_buf [0:3];
    logic dummy_d, dummy_oe, cmd_oe;

    always #5 clk = ~clk;

    mw_eeprom_slave #(.ADDR_W(8), .DATA_W(16), .WR_CYCLES(WR)) dut_i (
        .clk(clk), .rst(rst), .cs(cs), .sclk(sclk), .sdi(sdi),
        .sdo(sdo), .sdo_en(sdo_en)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic pulse(input logic b);
        @(negedge clk) sdi = b;
        @(negedge clk) sclk = 1'b1;
        @(negedge clk);
        @(negedge clk) begin last_d = sdo; last_oe = sdo_en; sclk = 1'b0; end
        @(negedge clk);
    endtask

    task automatic cs_up();
        @(negedge clk) cs = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic cs_down();
        @(negedge clk) cs = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic send_head(input int zeros, input logic [1:0] op, input logic [7:0] a);
        cmd_oe = 1'b0;
        for (int i = 0; i < zeros; i++) pulse(1'b0);
        pulse(1'b1);
        pulse(op[1]);
        cmd_oe |= last_oe;
        pulse(op[0]);
        cmd_oe |= last_oe;
        for (int i = 7; i >= 0; i--) begin
            pulse(a[i]);
            if (i != 0) cmd_oe |= last_oe;
        end
    endtask

    task automatic do_write(input logic [7:0] a, input logic [15:0] d, input bit wait_done);
        cs_up();
        send_head(0, 2'b01, a);
        for (int i = 15; i >= 0; i--) pulse(d[i]);
        cs_down();
        if (wait_done) repeat (WR + 10) @(negedge clk);
    endtask

    task automatic do_read(input int zeros, input logic [7:0] a, input int n);
        cs_up();
        send_head(zeros, 2'b10, a);
        dummy_d = last_d;
        dummy_oe = last_oe;
        for (int w = 0; w < n; w++) begin
            for (int i = 15; i >= 0; i--) begin
                pulse(1'b0);
                rd_buf[w][i] = last_d;
            end
        end
        cs_down();
    endtask

    task automatic do_ctl(input logic [1:0] sel, input logic [3:0] tail);
        cs_up();
        pulse(1'b1); pulse(1'b0); pulse(1'b0);
        pulse(sel[1]); pulse(sel[0]);
        for (int i = 3; i >= 0; i--) pulse(tail[i]);
        cs_down();
    endtask

    task automatic t_reset();
        check(sdo_en == 1'b0, "R10 reset oe", 32'(sdo_en), 0);
        cs_up();
        check(sdo_en == 1'b0, "R10 idle cs high oe", 32'(sdo_en), 0);
        cs_down();
    endtask

    task automatic t_locked_write();
        do_write(8'h20, 16'hBEEF, 1'b0);
        cs_up();
        check(sdo_en == 1'b0, "R5 no busy status after locked write", 32'(sdo_en), 0);
        cs_down();
    endtask

    task automatic t_write_read();
        do_ctl(2'b11, 4'b1011);
        do_write(8'h10, 16'h1234, 1'b1);
        do_read(0, 8'h10, 1);
        check(dummy_oe == 1'b1 && dummy_d == 1'b0, "R2 dummy bit", {dummy_oe, dummy_d}, 32'h2);
        check(cmd_oe == 1'b0, "R10 oe off during command", 32'(cmd_oe), 0);
        check(rd_buf[0] == 16'h1234, "R4 R2 write then read", 32'(rd_buf[0]), 32'h1234);
        do_write(8'h20, 16'hC3A5, 1'b1);
        do_read(5, 8'h20, 1);
        check(rd_buf[0] == 16'hC3A5, "R1 leading zeros skipped", 32'(rd_buf[0]), 32'hC3A5);
        check(dummy_d == 1'b0, "R1 dummy after zeros", 32'(dummy_d), 0);
    endtask

    task automatic t_stream();
        do_write(8'hFE, 16'hAAAA, 1'b1);
        do_write(8'hFF, 16'h0F0F, 1'b1);
        do_write(8'h00, 16'h5555, 1'b1);
        do_read(0, 8'hFE, 3);
        check(rd_buf[0] == 16'hAAAA, "R3 stream word 0", 32'(rd_buf[0]), 32'hAAAA);
        check(rd_buf[1] == 16'h0F0F, "R3 stream word 1", 32'(rd_buf[1]), 32'h0F0F);
        check(rd_buf[2] == 16'h5555, "R3 stream wrap to 0", 32'(rd_buf[2]), 32'h5555);
    endtask

    task automatic t_status_and_busy();
        do_write(8'h30, 16'h0A0A, 1'b1);
        do_write(8'h31, 16'h7E7E, 1'b0);
        repeat (3) @(negedge clk);
        cs_up();
        check(sdo_en == 1'b1 && sdo == 1'b0, "R8 busy status", {sdo_en, sdo}, 32'h2);
        send_head(0, 2'b01, 8'h30);
        for (int i = 15; i >= 0; i--) pulse(1'b1);
        check(sdo_en == 1'b1 && sdo == 1'b0, "R9 command ignored while busy", {sdo_en, sdo}, 32'h2);
        repeat (WR) @(negedge clk);
        check(sdo_en == 1'b1 && sdo == 1'b1, "R8 ready status", {sdo_en, sdo}, 32'h3);
        cs_down();
        do_read(0, 8'h30, 2);
        check(rd_buf[0] == 16'h0A0A, "R9 busy write rejected", 32'(rd_buf[0]), 32'h0A0A);
        check(rd_buf[1] == 16'h7E7E, "R4 second write stored", 32'(rd_buf[1]), 32'h7E7E);
    endtask

    task automatic t_abort();
        cs_up();
        send_head(0, 2'b01, 8'h10);
        for (int i = 15; i >= 6; i--) pulse(1'b1);
        cs_down();
        cs_up();
        check(sdo_en == 1'b0, "R11 no busy after aborted write", 32'(sdo_en), 0);
        cs_down();
        do_read(0, 8'h10, 1);
        check(rd_buf[0] == 16'h1234, "R11 aborted write no change", 32'(rd_buf[0]), 32'h1234);
        cs_up();
        send_head(0, 2'b10, 8'h10);
        pulse(1'b0); pulse(1'b0);
        check(sdo_en == 1'b1, "R2 oe on mid read", 32'(sdo_en), 1);
        @(negedge clk) cs = 1'b0;
        @(negedge clk);
        check(sdo_en == 1'b0, "R10 oe off at cs low", 32'(sdo_en), 0);
        @(negedge clk) cs = 1'b1;
        repeat (2) @(negedge clk);
        check(sdo_en == 1'b0, "R11 read aborted by cs low", 32'(sdo_en), 0);
        cs_down();
    endtask

    task automatic t_disable();
        do_ctl(2'b00, 4'b1111);
        do_write(8'h10, 16'hDEAD, 1'b0);
        cs_up();
        check(sdo_en == 1'b0, "R6 disable blocks write busy", 32'(sdo_en), 0);
        cs_down();
        do_read(0, 8'h10, 1);
        check(rd_buf[0] == 16'h1234, "R7 read while disabled", 32'(rd_buf[0]), 32'h1234);
        do_ctl(2'b11, 4'b0000);
        do_write(8'h10, 16'h4321, 1'b1);
        do_read(0, 8'h10, 1);
        check(rd_buf[0] == 16'h4321, "R6 re-enable accepts write", 32'(rd_buf[0]), 32'h4321);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        t_reset();
        t_locked_write();
        t_write_read();
        t_stream();
        t_status_and_busy();
        t_abort();
        t_disable();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule